// File: doc/BRIEF.md
# I2C Slave Peripheral with Clock-Stretch Handshake

This block connects a small processor to an I2C bus as a slave with a 7-bit address. It samples the bus clock and data lines through synchronisers and runs at a system clock at least eight times the bus clock rate. It drives the two lines only by pulling them low, through open-drain enables. Software reaches it through four byte-wide registers, chosen by a 2-bit select: own address (select 0, bits 6:0), control (select 1, bit 0 is the enable), status (select 2: bit 0 address-hit, bit 1 transmit direction, bit 2 bus busy) and data (select 3).

One interrupt line reports two kinds of event: an address match, and the end of a data byte. The address-hit status bit tells them apart. The interrupt stays up until software reads or writes the data register. When an event arrives, the block holds SCL low once the acknowledge clock has ended and keeps it low until that access. In receive mode the access is a read, which may be a dummy read. In transmit mode it is a write of the next byte to send.

Top module: `i2c_slv_top`

## Requirements
- R1: With the enable set, an SDA fall while SCL is high (START) sets the busy status bit (status bit 2). An SDA rise while SCL is high (STOP) clears it.
- R2: After START the first seven bits are taken MSB first and compared with own-address bits 6:0. On a match the address-hit bit (status bit 0) is set and irq rises.
- R3: The eighth bit after START is stored in the direction bit (status bit 1). A value of 1 means the master reads and the slave transmits.
- R4: On an address match the block pulls SDA low during the ninth clock as the acknowledge.
- R5: A non-matching address gets no acknowledge and raises no irq. SDA stays released until the next START.
- R6: In receive mode each data byte is acknowledged with a low ninth bit. irq then rises with address-hit cleared, and the byte can be read at select 3.
- R7: While irq is pending after an event, SCL is held low from the end of the ninth clock. Reading or writing select 3 clears irq and releases SCL. An access to any other select does not.
- R8: In transmit mode the byte written to select 3 is sent MSB first. SDA changes only while SCL is low.
- R9: A NACK from the master in the ninth clock of a transmitted byte ends the transfer. The slave then drives neither line until the next START.
- R10: With the enable bit cleared the block drives neither line, raises no irq and keeps busy at 0. Clearing it mid-transfer drops a pending irq.
- R11: A repeated START, whether in the middle of an address or after an ignored address, restarts address reception from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| sclPullLow | output | 1 | When 1, the bus clock line is pulled low |
| sdaPullLow | output | 1 | When 1, the bus data line is pulled low |
| regSel | input | 2 | Register select: 0 own address, 1 control, 2 status, 3 data |
| regWr | input | 1 | Register write strobe, one cycle per access |
| regRd | input | 1 | Register read strobe, one cycle per access |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt, high from an event until a data-register access |

## Verification
The assertions assume that software writes the data register only while SCL is low, and that the bus lines change no faster than the synchronisers can follow. They also assume SDA never changes in the same few system cycles as an SCL edge, so START and STOP are seen only where intended. The bench master keeps each line steady for many system cycles around every edge. It changes SDA only after waiting past the synchroniser delay following an SCL fall. Software accesses to the data register are made only while the block is stretching the clock. Random own addresses, directions, byte counts and data are drawn from a fixed seed, along with directed cases for repeated START, NACK and disabling during a transfer.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  localparam logic [1:0] SEL_OWN  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_TXACK,
    ST_IGNORE
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic shiftIn;
    logic shiftOut;
    logic captureRx;
  } ctrlStrobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic sclLevel;
    logic startDet;
    logic stopDet;
    logic byteDone;
    logic addrMatch;
    logic addrDir;
    logic sdaBit;
    logic txBit;
    logic dataAccess;
    logic en;
  } busEvent_t;

endpackage

// File: rtl/i2c_slv_dpath.sv
module i2c_slv_dpath
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  input  ctrlStrobe_t       strobe,
  input  logic              addrHit,
  input  logic              dirTx,
  input  logic              busy,
  output logic [DATA_W-1:0] regRdata,
  output busEvent_t         evt
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic [ADDR_W-1:0] ownAddr;
  logic enBit;
  logic [DATA_W-1:0] txReg, rxReg, shiftReg;
  logic [CNT_W-1:0] bitCnt;

  // two-stage synchronisers plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownAddr <= '0;
      enBit   <= 1'b0;
      txReg   <= '1;
    end else begin
      if (regWr && regSel == SEL_OWN)  ownAddr <= regWdata[ADDR_W-1:0];
      if (regWr && regSel == SEL_CTRL) enBit   <= regWdata[0];
      if (regWr && regSel == SEL_DATA) txReg   <= regWdata;
      else if (strobe.shiftOut)        txReg   <= {txReg[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      rxReg    <= '0;
    end else begin
      if (strobe.cntClr) bitCnt <= '0;
      else if (strobe.shiftIn || strobe.shiftOut) bitCnt <= bitCnt + 1'b1;
      if (strobe.shiftIn) shiftReg <= {shiftReg[DATA_W-2:0], sdaNow};
      if (strobe.captureRx) rxReg <= shiftReg;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_OWN:  regRdata[ADDR_W-1:0] = ownAddr;
      SEL_CTRL: regRdata[0] = enBit;
      SEL_STAT: regRdata[2:0] = {busy, dirTx, addrHit};
      default:  regRdata = rxReg;
    endcase
  end

  always_comb begin
    evt.sclRise    = sclNow && !sclPrev;
    evt.sclFall    = !sclNow && sclPrev;
    evt.sclLevel   = sclNow;
    evt.startDet   = sclNow && sclPrev && sdaPrev && !sdaNow;
    evt.stopDet    = sclNow && sclPrev && !sdaPrev && sdaNow;
    evt.byteDone   = (bitCnt == LAST_CNT);
    evt.addrMatch  = (shiftReg[DATA_W-1 -: ADDR_W] == ownAddr);
    evt.addrDir    = shiftReg[0];
    evt.sdaBit     = sdaNow;
    evt.txBit      = txReg[DATA_W-1];
    evt.dataAccess = (regWr || regRd) && (regSel == SEL_DATA);
    evt.en         = enBit;
  end

  // R6: the bit counter never runs past one byte
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_CNT);

  // R8: receive and transmit shifting never overlap
  p_one_shift_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shiftIn && strobe.shiftOut));

endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvent_t   evt,
  output ctrlStrobe_t strobe,
  output logic        sdaPullLow,
  output logic        sclPullLow,
  output logic        irq,
  output logic        addrHit,
  output logic        dirTx,
  output logic        busy
);

  busState_t state, nextState;
  logic pending, ackSeen, addrEvt, byteEvt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    addrEvt   = 1'b0;
    byteEvt   = 1'b0;
    if (!evt.en) begin
      nextState = ST_IDLE;
    end else if (evt.startDet) begin
      nextState     = ST_ADDR;
      strobe.cntClr = 1'b1;
    end else if (evt.stopDet) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: begin
          if (evt.sclRise && !evt.byteDone) strobe.shiftIn = 1'b1;
          if (evt.sclFall && evt.byteDone) begin
            if (evt.addrMatch) begin
              nextState = ST_ACK;
              addrEvt   = 1'b1;
            end else begin
              nextState = ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (evt.sclFall) begin
            strobe.cntClr = 1'b1;
            nextState     = dirTx ? ST_TX : ST_RX;
          end
        end
        ST_RX: begin
          if (evt.sclRise && !evt.byteDone) strobe.shiftIn = 1'b1;
          if (evt.sclFall && evt.byteDone) begin
            strobe.captureRx = 1'b1;
            byteEvt          = 1'b1;
            nextState        = ST_ACK;
          end
        end
        ST_TX: begin
          if (evt.byteDone) begin
            byteEvt   = 1'b1;
            nextState = ST_TXACK;
          end else if (evt.sclFall) begin
            strobe.shiftOut = 1'b1;
          end
        end
        ST_TXACK: begin
          if (evt.sclFall) begin
            if (ackSeen) begin
              nextState     = ST_TX;
              strobe.cntClr = 1'b1;
            end else begin
              nextState = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      addrHit <= 1'b0;
      dirTx   <= 1'b0;
      busy    <= 1'b0;
      ackSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_TXACK && evt.sclRise) ackSeen <= !evt.sdaBit;
      if (!evt.en) begin
        pending <= 1'b0;
        addrHit <= 1'b0;
        busy    <= 1'b0;
      end else begin
        if (evt.startDet) busy <= 1'b1;
        else if (evt.stopDet) busy <= 1'b0;
        if (addrEvt || byteEvt) pending <= 1'b1;
        else if (evt.dataAccess) pending <= 1'b0;
        if (addrEvt) begin
          addrHit <= 1'b1;
          dirTx   <= evt.addrDir;
        end else if (byteEvt) begin
          addrHit <= 1'b0;
        end
      end
    end
  end

  assign irq        = pending;
  assign sdaPullLow = (state == ST_ACK) || (state == ST_TX && !evt.txBit);
  assign sclPullLow = pending && (state == ST_RX || state == ST_TX);

  // R1: START marks the bus busy, a lone STOP frees it
  p_busy_on_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (evt.en && evt.startDet) |=> busy);
  p_free_on_stop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (evt.en && evt.stopDet && !evt.startDet) |=> !busy);

  // R2: a fresh address hit always comes with an interrupt
  p_hit_raises_irq_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrHit) |-> irq);

  // R7: a data-register access releases the stretched clock
  p_release_on_access_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evt.en && evt.dataAccess && !addrEvt && !byteEvt) |=> !sclPullLow);

  // R8: while transmitting, SDA holds steady across an SCL high phase
  p_sda_steady_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX && $past(state) == ST_TX && evt.sclLevel &&
     $past(evt.sclLevel) && !$past(evt.dataAccess)) |-> $stable(sdaPullLow));

  // R10: with the enable off the block goes quiet
  p_off_is_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !evt.en |=> (!irq && !busy && !sdaPullLow && !sclPullLow));

endmodule

// File: rtl/i2c_slv_top.sv
module i2c_slv_top
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);

  ctrlStrobe_t strobe;
  busEvent_t   evt;
  logic addrHit, dirTx, busy;

  i2c_slv_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .regSel(regSel),
    .regWr(regWr),
    .regRd(regRd),
    .regWdata(regWdata),
    .strobe(strobe),
    .addrHit(addrHit),
    .dirTx(dirTx),
    .busy(busy),
    .regRdata(regRdata),
    .evt(evt)
  );

  i2c_slv_ctrl uCtrl (
    .clk(clk),
    .rstN(rstN),
    .evt(evt),
    .strobe(strobe),
    .sdaPullLow(sdaPullLow),
    .sclPullLow(sclPullLow),
    .irq(irq),
    .addrHit(addrHit),
    .dirTx(dirTx),
    .busy(busy)
  );

endmodule

// File: tb/tb_i2c_slv_top.sv
module tb_i2c_slv_top;

  localparam int H = 40;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic mSclLow = 1'b0, mSdaLow = 1'b0;
  logic sclPullLow, sdaPullLow, irq;
  logic [1:0] regSel = 2'd0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [7:0] regWdata = 8'd0, regRdata;
  logic sclLine, sdaLine;

  assign sclLine = !(mSclLow || sclPullLow);
  assign sdaLine = !(mSdaLow || sdaPullLow);

  i2c_slv_top dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  int checks = 0, fails = 0, cycles = 0;
  int sdaGlitch = 0, sdaDriveCnt = 0;
  logic prevScl = 1'b1, prevDrv = 1'b0;

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual %0d cycles, expected completion earlier", cycles);
      finishRun();
    end
  end

  // R8 monitor: block's SDA drive must not change while SCL stays high
  always @(negedge clk) begin
    if (sclLine && prevScl && (sdaPullLow != prevDrv)) sdaGlitch++;
    if (sdaPullLow) sdaDriveCnt++;
    prevScl = sclLine;
    prevDrv = sdaPullLow;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expStatus(bit busy, bit dir, bit hit);
    return {busy, dir, hit};
  endfunction

  function automatic bit expMatch(logic [6:0] own, logic [6:0] sent);
    return own == sent;
  endfunction

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [1:0] sel, logic [7:0] val);
    @(negedge clk);
    regSel = sel; regWdata = val; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(logic [1:0] sel, output logic [7:0] val);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 val = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitSclHigh();
    while (sclLine !== 1'b1) @(negedge clk);
  endtask

  task automatic mBit(logic b, output logic s);
    mSdaLow = !b;
    waitCyc(H);
    mSclLow = 1'b0;
    waitSclHigh();
    waitCyc(H / 2);
    s = sdaLine;
    waitCyc(H / 2);
    mSclLow = 1'b1;
    waitCyc(8);
  endtask

  task automatic mStart();
    mSdaLow = 1'b0;
    waitCyc(H);
    mSclLow = 1'b0;
    waitSclHigh();
    waitCyc(H);
    mSdaLow = 1'b1;
    waitCyc(H);
    mSclLow = 1'b1;
    waitCyc(H);
  endtask

  task automatic mStop();
    mSdaLow = 1'b1;
    waitCyc(H);
    mSclLow = 1'b0;
    waitSclHigh();
    waitCyc(H);
    mSdaLow = 1'b0;
    waitCyc(H);
  endtask

  task automatic mByteOut(logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) mBit(d[i], s);
    mBit(1'b1, s);
    ack = !s;
  endtask

  task automatic mByteIn(logic giveAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      mBit(1'b1, s);
      d[i] = s;
    end
    mBit(!giveAck, s);
  endtask

  initial begin
    logic [7:0] st, d, data;
    logic ack;
    logic s;
    logic [6:0] own, sent;
    bit dir;
    int n;
    void'($urandom(32'h1DC5));

    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);

    // reset state
    chk("R10 reset irq", irq, 0);
    chk("R10 reset sclPullLow", sclPullLow, 0);
    chk("R10 reset sdaPullLow", sdaPullLow, 0);
    regRead(2'd2, st);
    chk("R10 reset status", st, 0);

    // disabled: no response
    own = 7'h2A;
    regWrite(2'd0, {1'b0, own});
    sdaDriveCnt = 0;
    mStart();
    regRead(2'd2, st);
    chk("R10 busy stays 0 when off", st, 0);
    mByteOut({own, 1'b0}, ack);
    chk("R10 no ack when off", ack, 0);
    chk("R10 no irq when off", irq, 0);
    chk("R10 no SDA drive when off", sdaDriveCnt, 0);
    mStop();

    // enable, receive
    regWrite(2'd1, 8'd1);
    mStart();
    regRead(2'd2, st);
    chk("R1 busy after START", st[2], 1);
    mByteOut({own, 1'b0}, ack);
    chk("R4 ack on address match", ack, 1);
    chk("R2 irq on address match", irq, 1);
    regRead(2'd2, st);
    chk("R2 R3 status after write address", st, expStatus(1, 0, 1));
    waitCyc(4);
    chk("R7 SCL stretched after address", sclPullLow, 1);
    regRead(2'd0, st);
    waitCyc(2);
    chk("R7 other select keeps stretch", sclPullLow, 1);
    regRead(2'd3, d);
    waitCyc(2);
    chk("R7 irq cleared by dummy read", irq, 0);
    chk("R7 SCL released by dummy read", sclPullLow, 0);
    for (int k = 0; k < 4; k++) begin
      data = 8'($urandom);
      mByteOut(data, ack);
      chk("R6 data byte acked", ack, 1);
      chk("R6 irq after data byte", irq, 1);
      regRead(2'd2, st);
      chk("R6 address-hit cleared on data", st[0], 0);
      waitCyc(2);
      chk("R7 SCL stretched after data", sclPullLow, 1);
      regRead(2'd3, d);
      chk("R6 received byte", d, data);
      waitCyc(2);
      chk("R7 released after read", sclPullLow, 0);
    end
    mStop();
    regRead(2'd2, st);
    chk("R1 busy cleared by STOP", st[2], 0);

    // non-matching address
    sdaDriveCnt = 0;
    mStart();
    mByteOut({own ^ 7'h11, 1'b0}, ack);
    chk("R5 no ack on mismatch", ack, 0);
    chk("R5 no irq on mismatch", irq, 0);
    mByteOut(8'h00, ack);
    chk("R5 data after mismatch not acked", ack, 0);
    chk("R5 SDA never driven", sdaDriveCnt, 0);
    // repeated START after an ignored address
    mStart();
    mBit(1'b1, s); mBit(1'b0, s); mBit(1'b1, s);
    // repeated START mid-address
    mStart();
    mByteOut({own, 1'b0}, ack);
    chk("R11 ack after repeated START", ack, 1);
    chk("R11 irq after repeated START", irq, 1);
    regRead(2'd3, d);
    mStop();

    // transmit
    sdaGlitch = 0;
    mStart();
    mByteOut({own, 1'b1}, ack);
    chk("R4 ack on read address", ack, 1);
    regRead(2'd2, st);
    chk("R3 direction set for read", st, expStatus(1, 1, 1));
    waitCyc(4);
    chk("R7 stretch before first tx byte", sclPullLow, 1);
    for (int k = 0; k < 3; k++) begin
      data = 8'($urandom);
      regWrite(2'd3, data);
      waitCyc(2);
      chk("R7 released by data write", sclPullLow, 0);
      mByteIn(k != 2, d);
      chk("R8 transmitted byte", d, data);
      chk("R6 irq after tx byte", irq, 1);
      if (k != 2) begin
        waitCyc(4);
        chk("R7 stretch between tx bytes", sclPullLow, 1);
      end
    end
    waitCyc(4);
    chk("R9 no SCL hold after NACK", sclPullLow, 0);
    chk("R9 SDA released after NACK", sdaPullLow, 0);
    mBit(1'b1, s);
    chk("R9 bus idle-high after NACK", s, 1);
    regRead(2'd3, d);
    mStop();
    chk("R8 SDA steady while SCL high", sdaGlitch, 0);

    // disabling mid-transfer
    mStart();
    mByteOut({own, 1'b0}, ack);
    chk("R2 irq before disable", irq, 1);
    regWrite(2'd1, 8'd0);
    waitCyc(2);
    chk("R10 irq dropped on disable", irq, 0);
    chk("R10 SCL released on disable", sclPullLow, 0);
    regRead(2'd2, st);
    chk("R10 busy cleared on disable", st[2], 0);
    mStop();
    regWrite(2'd1, 8'd1);

    // random transactions
    sdaGlitch = 0;
    for (int t = 0; t < 8; t++) begin
      own = 7'($urandom);
      regWrite(2'd0, {1'b0, own});
      sent = ($urandom % 2 == 0) ? own : (own ^ 7'(1 + $urandom % 127));
      dir = 1'($urandom);
      n = 1 + int'($urandom % 3);
      mStart();
      mByteOut({sent, dir}, ack);
      chk("R2 random ack", ack, int'(expMatch(own, sent)));
      chk("R2 random irq", irq, int'(expMatch(own, sent)));
      if (expMatch(own, sent)) begin
        regRead(2'd2, st);
        chk("R3 random status", st, expStatus(1, dir, 1));
        if (!dir) begin
          regRead(2'd3, d);
          for (int k = 0; k < n; k++) begin
            data = 8'($urandom);
            mByteOut(data, ack);
            chk("R6 random rx ack", ack, 1);
            regRead(2'd3, d);
            chk("R6 random rx data", d, data);
          end
        end else begin
          for (int k = 0; k < n; k++) begin
            data = 8'($urandom);
            regWrite(2'd3, data);
            mByteIn(k != n - 1, d);
            chk("R8 random tx data", d, data);
          end
          regRead(2'd3, d);
        end
      end else begin
        sdaDriveCnt = 0;
        mByteOut(8'($urandom), ack);
        chk("R5 random mismatch no ack", ack, 0);
        chk("R5 random mismatch no irq", irq, 0);
        chk("R5 random mismatch no drive", sdaDriveCnt, 0);
      end
      mStop();
      regRead(2'd2, st);
      chk("R1 random busy cleared", st[2], 0);
    end
    chk("R8 random SDA steady while SCL high", sdaGlitch, 0);

    finishRun();
  end

endmodule